// File: doc/BRIEF.md
# Crosswise Column-Sum Array Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. All of the operand-bit AND terms are formed first, in parallel. The product is then built one column at a time. Column k adds every cross term whose two bit indices sum to k, and it also adds the carries left over from the lower columns. The low bit of each column sum becomes product bit k. The remaining high bits of that sum feed the next one, two and three columns up on a fixed schedule. Each column sum is a small counter, which is the job that n:3 compressors do in hardware.

A build-time switch selects a second form. In that form, four half-width crosswise units work on the quadrants of the AND-term matrix, and their results are merged with adders. Both forms give the same bits. One operand pair is accepted on every clock in which `in_valid` is high. The product is registered and appears one clock later with `out_valid`.

Top module: `crosswise_mult`

## Requirements
- R1: `prod` equals the unsigned product `a_in * b_in` (a 16-bit zero-extended result) for every one of the 65536 operand pairs.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `prod` holds the product of the operands sampled at that edge. One new pair can be accepted on every cycle.
- R3: When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `prod` keeps its previous value, whatever the operand inputs carry.
- R4: While `rst` is high at a rising edge (synchronous, active high), `out_valid` goes low and `prod` goes to zero after that edge.
- R5: The corner cases are exact: 0×0 gives 0x0000, 255×255 gives 0xFE01, and a factor of 1 returns the other operand.
- R6: The quadrant-composed form (`COMPOSED`=1) gives a product identical to the flat column form on every pair.
- R7: Product bit 0 is the AND of the two operand low bits, because column 0 passes no carry upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| a_in | input | N | Multiplicand |
| b_in | input | N | Multiplier |
| out_valid | output | 1 | `prod` carries a fresh result |
| prod | output | 2N | Registered product |

## Verification
The bench builds two copies with N=8: one with `COMPOSED`=0 and one with `COMPOSED`=1. It streams every operand pair through both back to back. This checks the column carry schedule of the flat form and the quadrant merge of the composed form against a plain multiply. It also checks the two forms against each other on every pair. Held-operand and reset checks cover the register stage around them.

// File: rtl/crosswise_mult.sv
module crosswise_mult #(
  parameter int N        = 8,
  parameter bit COMPOSED = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic           out_valid,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;
  localparam int H  = N / 2;
  localparam int CW = $clog2(PW + 1) + 1;

  logic [N*N-1:0] ppf;
  logic [PW-1:0]  comb_prod;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign ppf[i*N+j] = a_in[i] & b_in[j];
    end
  end

  function automatic logic [PW-1:0] colsum(input logic [N*N-1:0] m,
                                           input int bi, input int bj,
                                           input int n);
    logic [CW-1:0] s;
    logic [CW-1:0] cy;
    logic [PW-1:0] r;
    cy = '0;
    r  = '0;
    for (int k = 0; k < PW; k++) begin
      s = cy;
      if (k < 2 * n) begin
        for (int i = 0; i < N; i++) begin
          if (i < n && k - i >= 0 && k - i < n)
            s = s + CW'(m[(bi + i) * N + bj + k - i]);
        end
      end
      r[k] = s[0];
      cy   = s >> 1;
    end
    return r;
  endfunction

  if (COMPOSED) begin : g_quad
    logic [PW-1:0] q_ll, q_lh, q_hl, q_hh, q_mid;
    assign q_ll  = colsum(ppf, 0, 0, H);
    assign q_lh  = colsum(ppf, 0, H, H);
    assign q_hl  = colsum(ppf, H, 0, H);
    assign q_hh  = colsum(ppf, H, H, H);
    assign q_mid = q_lh + q_hl;
    assign comb_prod = q_ll + (q_mid << H) + (q_hh << N);
  end else begin : g_flat
    assign comb_prod = colsum(ppf, 0, 0, N);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod <= comb_prod;
    end
  end

  logic [PW-1:0] a_wide, b_wide;
  assign a_wide = {{N{1'b0}}, a_in};
  assign b_wide = {{N{1'b0}}, b_in};

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && prod == $past(a_wide) * $past(b_wide))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(prod))); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && prod == '0)); // R4
  AST_LSB_COLUMN: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod[0] == ($past(a_in[0]) & $past(b_in[0]))); // R7
endmodule

// File: tb/crosswise_mult_tb_top.sv
module crosswise_mult_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic ov_f, ov_c;
  logic [15:0] p_f, p_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crosswise_mult #(.N(8), .COMPOSED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .out_valid(ov_f), .prod(p_f));
  crosswise_mult #(.N(8), .COMPOSED(1'b1)) dut_c_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a), .b_in(b),
    .out_valid(ov_c), .prod(p_c));

  localparam logic [31:0] VEC [8] = '{
    {8'h00, 8'h00, 16'h0000}, {8'hFF, 8'hFF, 16'hFE01},
    {8'h01, 8'hFF, 16'h00FF}, {8'hFF, 8'h01, 16'h00FF},
    {8'h01, 8'h01, 16'h0001}, {8'h80, 8'h80, 16'h4000},
    {8'h0F, 8'hF0, 16'h0E10}, {8'hAA, 8'h55, 16'h3872}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [15:0] exp);
    chk(req, {31'd0, ov_f}, 32'd1);
    chk(req, {16'd0, p_f}, {16'd0, exp});
    chk("R6", {16'd0, p_c}, {16'd0, p_f});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 valid", {31'd0, ov_f}, 32'd0);
    chk("R4 prod", {16'd0, p_f}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      a = VEC[v][31:24]; b = VEC[v][23:16]; in_valid = 1'b1;
      @(negedge clk);
      check_out("R5", VEC[v][15:0]);
      chk("R7", {31'd0, p_f[0]}, {31'd0, a[0] & b[0]});
    end

    in_valid = 1'b0; a = 8'h5A; b = 8'hC3;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk("R3 valid", {31'd0, ov_f}, 32'd0);
      chk("R3 hold", {16'd0, p_f}, {16'd0, 16'h3872});
    end

    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 256; bi++) begin
        @(negedge clk);
        if (ai != 0 || bi != 0) check_out("R1/R2", 16'(a) * 16'(b));
        a = 8'(ai); b = 8'(bi); in_valid = 1'b1;
      end
    end
    @(negedge clk);
    check_out("R1/R2", 16'(a) * 16'(b));

    in_valid = 1'b1; a = 8'h33; b = 8'h77; rst = 1'b1;
    @(negedge clk);
    chk("R4 valid", {31'd0, ov_f}, 32'd0);
    chk("R4 prod", {16'd0, p_f}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R2", 16'h17B5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule